// File: doc/BRIEF.md
# Button-Stepped Tick Rate Generator

This block derives a one-clock enable pulse from the main clock so that a slower sequencer, such as an LED chaser, can advance on each pulse. The pulse period is taken from a parameter `BASE_DIV`. A push button changes the pulse rate. Each press moves to the next speed setting in a fixed cycle: one times the base rate, then two, four and eight times, then back to one times.

The raw button is active low. It passes through a two-flop synchroniser and then a debounce filter. The filter adopts a new level only after that level has held for `DEBOUNCE_CYCLES` clocks. Only the filtered falling edge, which is the start of a press, advances the speed. Every speed change restarts the tick counter from zero, so the first pulse at the new rate arrives exactly one new period later.

Top module: `rate_tick_gen`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0 and `speed_o` is 0. After reset is released, the first tick appears exactly `BASE_DIV` clocks later.
- R2: Each accepted press increments `speed_o` modulo 4. The speed encoding is 0 = 1x, 1 = 2x, 2 = 4x, 3 = 8x. Starting from reset, the presses give 1, 2, 3, 0, 1 and so on, so the fifth press returns to 2x.
- R3: While the speed is constant, successive ticks are exactly `BASE_DIV >> speed_o` clocks apart. Each tick lasts one clock whenever that period is larger than 1.
- R4: When the period is 1 (`BASE_DIV` = 8 at speed 3, so the divider terminal value is 0), `tick_o` is high on every clock.
- R5: On the clock in which `speed_o` takes a new value, `tick_o` is 0. The next tick follows exactly `BASE_DIV >> speed_o` clocks later.
- R6: A low pulse on `btn_ni` lasting fewer than `DEBOUNCE_CYCLES` clocks leaves `speed_o` unchanged.
- R7: Holding the button steps the speed exactly once. Releasing the button never steps it.
- R8: Suppose `btn_ni` goes low before clock edge F and stays low. Then `speed_o` changes at edge F + `DEBOUNCE_CYCLES` + 2 and at no earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Raw push button, low while pressed |
| tick_o | output | 1 | One-clock pacing pulse |
| speed_o | output | 2 | Current speed index (0 = 1x … 3 = 8x) |

## Verification
A corrupted speed index shows up at once on `speed_o`. Within one period it also shows up as a wrong tick spacing, because every spacing is measured against `BASE_DIV >> speed`. A tick counter that is not cleared on a speed change moves the first tick after a press away from its expected offset. A wrong debounce count moves the speed change by a whole clock, which the exact-latency check catches, or lets a short glitch step the speed. The bench uses `BASE_DIV` = 8, so the sweep reaches the terminal value of 0, in which the tick stays high on every clock.

// File: rtl/rate_tick_pkg.sv
package rate_tick_pkg;

    typedef enum logic [1:0] {
        SPD_X1 = 2'd0,
        SPD_X2 = 2'd1,
        SPD_X4 = 2'd2,
        SPD_X8 = 2'd3
    } speed_e;

    localparam int unsigned NUM_SPEEDS = 4;

    typedef struct packed {
        logic meta;
        logic sync;
    } sync_st_t;

endpackage

// File: rtl/rate_btn_sync.sv
module rate_btn_sync
    import rate_tick_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_ni,
    output logic sync_no
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_ni;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{meta: 1'b1, sync: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_no = st_q.sync;
endmodule

// File: rtl/rate_btn_filter.sv
module rate_btn_filter #(
    parameter int unsigned DEBOUNCE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_ni,
    output logic press_o
);
    localparam int unsigned DB_W = (DEBOUNCE_CYCLES > 2) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_CYCLES - 1);

    typedef struct packed {
        logic            stable;
        logic [DB_W-1:0] cnt;
        logic            press;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.press = 1'b0;
        if (level_ni == st_q.stable) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == DB_LAST) begin
            st_d.stable = level_ni;
            st_d.cnt    = '0;
            st_d.press  = ~level_ni;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{stable: 1'b1, cnt: '0, press: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign press_o = st_q.press;
endmodule

// File: rtl/rate_speed_step.sv
module rate_speed_step
    import rate_tick_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   step_i,
    output speed_e speed_o
);
    speed_e speed_d, speed_q;

    always_comb begin
        speed_d = speed_q;
        if (step_i) begin
            speed_d = speed_e'(speed_q + 2'd1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            speed_q <= SPD_X1;
        end else begin
            speed_q <= speed_d;
        end
    end

    assign speed_o = speed_q;
endmodule

// File: rtl/rate_tick_div.sv
module rate_tick_div
    import rate_tick_pkg::*;
#(
    parameter int unsigned BASE_DIV = 64
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  speed_e speed_i,
    input  logic   restart_i,
    output logic   tick_o
);
    localparam int unsigned CNT_W = $clog2(BASE_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    logic [CNT_W-1:0] term_tab [NUM_SPEEDS];

    for (genvar k = 0; k < NUM_SPEEDS; k++) begin : g_term
        assign term_tab[k] = CNT_W'((BASE_DIV >> k) - 1);
    end

    div_st_t          st_d, st_q;
    logic [CNT_W-1:0] term_w;

    assign term_w = term_tab[speed_i];

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt == term_w) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
    import rate_tick_pkg::*;
#(
    parameter int unsigned BASE_DIV        = 64,
    parameter int unsigned DEBOUNCE_CYCLES = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       btn_ni,
    output logic       tick_o,
    output logic [1:0] speed_o
);
    logic   btn_sync_w;
    logic   press_w;
    speed_e speed_w;

    rate_btn_sync sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_ni  (btn_ni),
        .sync_no (btn_sync_w)
    );

    rate_btn_filter #(
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) filt_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_ni (btn_sync_w),
        .press_o  (press_w)
    );

    rate_speed_step step_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (press_w),
        .speed_o (speed_w)
    );

    rate_tick_div #(
        .BASE_DIV(BASE_DIV)
    ) div_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .speed_i   (speed_w),
        .restart_i (press_w),
        .tick_o    (tick_o)
    );

    assign speed_o = speed_w;
endmodule

// File: rtl/rate_tick_gen_chk.sv
module rate_tick_gen_chk #(
    parameter int unsigned BASE_DIV = 64
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic [1:0] speed_i,
    input logic       press_i
);
    // R1: reset forces the idle output state
    p_reset_idle_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (speed_i == 2'd0 && !tick_i));

    // R2: speed only ever steps by one, wrapping
    p_speed_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(speed_i) |-> speed_i == $past(speed_i) + 2'd1);

    // R3: single-cycle tick whenever the period exceeds one clock
    p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && ((BASE_DIV >> speed_i) > 1)) |=> !tick_i);

    // R5: the tick is quiet in the cycle a new speed takes effect
    p_tick_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(speed_i) |-> !tick_i);

    // R7: the speed moves only after a filtered press edge
    p_step_on_press_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(speed_i) |-> $past(press_i));
endmodule

bind rate_tick_gen rate_tick_gen_chk #(
    .BASE_DIV(BASE_DIV)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_o),
    .speed_i (speed_o),
    .press_i (press_w)
);

// File: tb/rate_tick_gen_tb_top.sv
`timescale 1ns/1ps
module rate_tick_gen_tb_top;
    localparam int unsigned BASE = 8;
    localparam int unsigned DB   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_n = 1'b1;
    logic       tick;
    logic [1:0] speed;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rate_tick_gen #(
        .BASE_DIV(BASE),
        .DEBOUNCE_CYCLES(DB)
    ) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .btn_ni  (btn_n),
        .tick_o  (tick),
        .speed_o (speed)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts negedges until tick is seen high
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 1000);
    endtask

    task automatic do_press(input int old_spd);
        int new_spd;
        int per;
        int n;
        new_spd = (old_spd + 1) % 4;
        per     = BASE >> new_spd;
        @(negedge clk);
        btn_n = 1'b0;
        repeat (DB + 2) @(posedge clk);
        @(negedge clk);
        chk("R8 no early step", int'(speed), old_spd);
        @(negedge clk);
        chk("R8/R2 step after latency", int'(speed), new_spd);
        chk("R5 tick low on change", int'(tick), 0);
        wait_tick(n);
        chk("R5 first tick offset", n, per);
        for (int j = 0; j < 3; j++) begin
            wait_tick(n);
            if (per == 1) chk("R4 tick every clock", n, per);
            else          chk("R3 tick spacing", n, per);
        end
        btn_n = 1'b1;
        repeat (2 * DB + 6) @(negedge clk);
        chk("R7 held/released steps once", int'(speed), new_spd);
    endtask

    initial begin
        int n;
        int spd;
        repeat (3) @(negedge clk);
        chk("R1 reset speed", int'(speed), 0);
        chk("R1 reset tick", int'(tick), 0);
        rst_n = 1'b1;
        wait_tick(n);
        chk("R1 first tick after reset", n, BASE);
        wait_tick(n);
        chk("R3 base spacing", n, BASE);

        spd = 0;
        for (int i = 0; i < 9; i++) begin
            do_press(spd);
            spd = (spd + 1) % 4;
        end

        // short glitch must be filtered
        for (int g = 1; g < DB; g++) begin
            @(negedge clk);
            btn_n = 1'b0;
            repeat (g) @(negedge clk);
            btn_n = 1'b1;
            repeat (2 * DB + 6) @(negedge clk);
            chk("R6 glitch ignored", int'(speed), spd);
        end

        // reset during run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset speed", int'(speed), 0);
        chk("R1 mid-run reset tick", int'(tick), 0);
        rst_n = 1'b1;
        wait_tick(n);
        chk("R1 tick after mid-run reset", n, BASE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule